// File: doc/BRIEF.md
# Virtualization Trap Control Register

This block holds a 32-bit hypervisor configuration word and turns its fields into trap decisions. Software reaches the word through a coprocessor-style request that carries the coprocessor number and the opc1, CRn, CRm and opc2 selectors, a read/write flag and write data. Each access is checked against the current privilege level, the secure-state bit and the hypervisor's access-trap control. A permitted access reads or updates the word. A refused access returns either an undefined-instruction flag or a trap-to-hypervisor flag with a syndrome class.

The stored fields drive the effective control outputs. In host mode, where both host bits are 1, the trap enables for TLB maintenance, cache maintenance and ID-group-4 accesses are forced to zero. The stage-2 non-cacheable controls apply only while stage-2 translation is on and the core is outside the hypervisor's own regime. A one-hot instruction-class vector describes the guest instruction being executed. The block reports combinationally whether that instruction traps, and with which syndrome class.

Requests use a valid/ready handshake. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending, or when the pending response is taken in the same cycle. The response appears one cycle after acceptance. It holds all of its fields stable until `resp_ready` is seen high.

Top module: `hv_trap_ctl`

## Requirements
- R1: Only coprocessor 15 with opc1=4, CRn=1, CRm=1 and opc2=4 selects the register. Any other encoding returns a response with read data 0, no undefined flag and no trap flag, and leaves the register unchanged.
- R2: A selected access at privilege level 0 responds with undefined=1 and read data 0, and does not write.
- R3: At level 1, a selected access responds with trap=1 and syndrome 0x03 when hypervisor-enable and access-trap are both 1. Otherwise it responds with undefined=1. It never writes.
- R4: At level 2, reads return the stored word and writes update it. A write response carries read data 0.
- R5: At level 3 with the secure bit set, a selected access is undefined. With the secure bit clear, it behaves as at level 2.
- R6: Bits 31:23, 21, 19, 16:7 and 3:2 always read as 0, and writes to them are dropped.
- R7: Reset clears every stored bit, so a read just after reset returns 0.
- R8: While host bits e2h and tge are both 1, effective bits 22, 20, 18 and 17 are 0, and the guest instructions those bits guard do not trap.
- R9: Guest trap mapping from `insn_class`: bit0 (inner-shareable TLB op) traps on field 22; bit1 (point-of-unification cache op) on 20; bit2 (inner-shareable I-cache invalidate-all) on 18; bit3 (ID-group-4 read) on 17; bit4 (single error-record transfer) and bit5 (double error-record transfer) on field 4. A trap occurs only for Non-secure level 1 execution, or Non-secure levels 0 and 1 for bit3. The syndrome is 0x04 for bit5 and 0x03 for all others.
- R10: Effective bits 1 and 0 equal the stored bits only while `s2_en` is 1 and the level is not 2. Otherwise they are 0.
- R11: The response is valid exactly one cycle after acceptance. It holds stable while `resp_ready` is 0, and `req_ready` is 0 during that time.
- R12: When the optional feature groups are absent (error-record group for bits 5:4, bit 6, and the trap group for bits 22, 20, 18 and 17), those bits read as 0 and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_cp | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | opc1 selector |
| req_crn | input | 4 | CRn selector |
| req_crm | input | 4 | CRm selector |
| req_opc2 | input | 3 | opc2 selector |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_rdata | output | 32 | Read data |
| resp_undef | output | 1 | Access is undefined |
| resp_trap | output | 1 | Access traps to the hypervisor |
| resp_syn | output | 6 | Syndrome class of the access trap |
| cur_el | input | 2 | Current privilege level |
| sec_state | input | 1 | 1 = Secure |
| hyp_en | input | 1 | Hypervisor enabled |
| hyp_acc_trap | input | 1 | Hypervisor traps level-1 access to this register |
| host_e2h | input | 1 | Host-mode bit e2h |
| host_tge | input | 1 | Host-mode bit tge |
| s2_en | input | 1 | Stage-2 translation enabled |
| insn_class | input | 6 | One-hot guest instruction class |
| guest_trap | output | 1 | Guest instruction traps |
| guest_syn | output | 6 | Syndrome class of the guest trap |
| eff_ctrl | output | 32 | Effective control word |

## Verification
On every cycle, the assertions check the privilege verdicts for level 0, level 1 and Secure level 3 one cycle after acceptance. They also check the zero-valued reserved bits on read data, the host-mode masking and the Secure suppression of guest traps, and that a stalled response stays stable. They confirm that an unselected encoding leaves the stored word unchanged. Only the bench scenarios can show the full stored value across write/read sequences, the exact guest-trap syndromes for each class, the stage-2 gating, and how a build with the optional feature groups removed behaves.

// File: rtl/hv_trap_pkg.sv
package hv_trap_pkg;
  localparam logic [3:0] SEL_CP   = 4'd15;
  localparam logic [2:0] SEL_OPC1 = 3'd4;
  localparam logic [3:0] SEL_CRN  = 4'd1;
  localparam logic [3:0] SEL_CRM  = 4'd1;
  localparam logic [2:0] SEL_OPC2 = 3'd4;

  localparam int FB_TLB_IS = 22;
  localparam int FB_POU    = 20;
  localparam int FB_ICAB   = 18;
  localparam int FB_ID4    = 17;
  localparam int FB_NCOH   = 6;
  localparam int FB_EXTAB  = 5;
  localparam int FB_ERREC  = 4;
  localparam int FB_S2I    = 1;
  localparam int FB_S2D    = 0;

  localparam logic [31:0] GRP_TRAP = (32'd1 << FB_TLB_IS) | (32'd1 << FB_POU) |
                                     (32'd1 << FB_ICAB) | (32'd1 << FB_ID4);
  localparam logic [31:0] GRP_RAS  = (32'd1 << FB_EXTAB) | (32'd1 << FB_ERREC);
  localparam logic [31:0] GRP_NCOH = (32'd1 << FB_NCOH);
  localparam logic [31:0] GRP_S2   = (32'd1 << FB_S2I) | (32'd1 << FB_S2D);

  localparam int IC_TLB_IS = 0;
  localparam int IC_POU    = 1;
  localparam int IC_ICAB   = 2;
  localparam int IC_ID4    = 3;
  localparam int IC_ERR1   = 4;
  localparam int IC_ERR2   = 5;
  localparam int IC_W      = 6;

  localparam int SYN_W = 6;
  localparam logic [SYN_W-1:0] SYN_ONE = 6'h03;
  localparam logic [SYN_W-1:0] SYN_TWO = 6'h04;

  typedef enum logic [1:0] {VERD_OK, VERD_UNDEF, VERD_TRAP} verdict_e;
endpackage

// File: rtl/hv_access_gate.sv
module hv_access_gate
  import hv_trap_pkg::*;
(
  input  logic [3:0] cp,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  input  logic [1:0] el,
  input  logic       secure,
  input  logic       hyp_en,
  input  logic       hyp_acc_trap,
  output logic       hit,
  output verdict_e   verdict
);
  assign hit = (cp == SEL_CP) && (opc1 == SEL_OPC1) && (crn == SEL_CRN) &&
               (crm == SEL_CRM) && (opc2 == SEL_OPC2);

  always_comb begin
    unique case (el)
      2'd0:    verdict = VERD_UNDEF;
      2'd1:    verdict = (hyp_en && hyp_acc_trap) ? VERD_TRAP : VERD_UNDEF;
      2'd2:    verdict = VERD_OK;
      default: verdict = secure ? VERD_UNDEF : VERD_OK;
    endcase
  end
endmodule

// File: rtl/hv_cfg_store.sv
module hv_cfg_store #(
  parameter int          W     = 32,
  parameter logic [31:0] WMASK = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wdata & WMASK[W-1:0];
  end
endmodule

// File: rtl/hv_trap_eval.sv
module hv_trap_eval
  import hv_trap_pkg::*;
(
  input  logic [31:0]      cfg_q,
  input  logic [1:0]       el,
  input  logic             secure,
  input  logic             host_e2h,
  input  logic             host_tge,
  input  logic             s2_en,
  input  logic [IC_W-1:0]  insn_class,
  output logic [31:0]      eff,
  output logic             trap,
  output logic [SYN_W-1:0] syn
);
  logic host_mode, ns_el1, ns_el01;
  logic [IC_W-1:0] hits;

  assign host_mode = host_e2h && host_tge;
  assign ns_el1    = !secure && (el == 2'd1);
  assign ns_el01   = !secure && (el <= 2'd1);

  always_comb begin
    eff = cfg_q & ~GRP_S2;
    if (host_mode) eff = eff & ~GRP_TRAP;
    if (s2_en && el != 2'd2) eff = eff | (cfg_q & GRP_S2);
  end

  assign hits[IC_TLB_IS] = insn_class[IC_TLB_IS] && eff[FB_TLB_IS] && ns_el1;
  assign hits[IC_POU]    = insn_class[IC_POU]    && eff[FB_POU]    && ns_el1;
  assign hits[IC_ICAB]   = insn_class[IC_ICAB]   && eff[FB_ICAB]   && ns_el1;
  assign hits[IC_ID4]    = insn_class[IC_ID4]    && eff[FB_ID4]    && ns_el01;
  assign hits[IC_ERR1]   = insn_class[IC_ERR1]   && eff[FB_ERREC]  && ns_el1;
  assign hits[IC_ERR2]   = insn_class[IC_ERR2]   && eff[FB_ERREC]  && ns_el1;

  assign trap = |hits;
  assign syn  = !trap ? '0 : (hits[IC_ERR2] ? SYN_TWO : SYN_ONE);
endmodule

// File: rtl/hv_trap_ctl.sv
module hv_trap_ctl
  import hv_trap_pkg::*;
#(
  parameter bit HAS_TRAP_GRP = 1'b1,
  parameter bit HAS_RAS_GRP  = 1'b1,
  parameter bit HAS_NCOH     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cp,
  input  logic [2:0]       req_opc1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_opc2,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [31:0]      resp_rdata,
  output logic             resp_undef,
  output logic             resp_trap,
  output logic [SYN_W-1:0] resp_syn,
  input  logic [1:0]       cur_el,
  input  logic             sec_state,
  input  logic             hyp_en,
  input  logic             hyp_acc_trap,
  input  logic             host_e2h,
  input  logic             host_tge,
  input  logic             s2_en,
  input  logic [IC_W-1:0]  insn_class,
  output logic             guest_trap,
  output logic [SYN_W-1:0] guest_syn,
  output logic [31:0]      eff_ctrl
);
  localparam logic [31:0] WMASK = GRP_S2 |
                                  (HAS_TRAP_GRP ? GRP_TRAP : 32'h0) |
                                  (HAS_RAS_GRP  ? GRP_RAS  : 32'h0) |
                                  (HAS_NCOH     ? GRP_NCOH : 32'h0);

  logic        hit, accept, wr_en;
  verdict_e    verdict;
  logic [31:0] cfg_q;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && hit && (verdict == VERD_OK) && req_write;

  hv_access_gate u_gate (
    .cp(req_cp), .opc1(req_opc1), .crn(req_crn), .crm(req_crm), .opc2(req_opc2),
    .el(cur_el), .secure(sec_state), .hyp_en(hyp_en), .hyp_acc_trap(hyp_acc_trap),
    .hit(hit), .verdict(verdict)
  );

  hv_cfg_store #(.W(32), .WMASK(WMASK)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(req_wdata), .cfg_q(cfg_q)
  );

  hv_trap_eval u_eval (
    .cfg_q(cfg_q), .el(cur_el), .secure(sec_state), .host_e2h(host_e2h),
    .host_tge(host_tge), .s2_en(s2_en), .insn_class(insn_class),
    .eff(eff_ctrl), .trap(guest_trap), .syn(guest_syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_undef <= 1'b0;
      resp_trap  <= 1'b0;
      resp_syn   <= '0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_rdata <= (hit && verdict == VERD_OK && !req_write) ? cfg_q : '0;
      resp_undef <= hit && (verdict == VERD_UNDEF);
      resp_trap  <= hit && (verdict == VERD_TRAP);
      resp_syn   <= (hit && verdict == VERD_TRAP) ? SYN_ONE : '0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  // R2: level 0 access is undefined
  a_r2_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && cur_el == 2'd0) |=> (resp_valid && resp_undef && !resp_trap));
  // R3: level 1 access with trap enabled reports class 0x03
  a_r3_el1_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && cur_el == 2'd1 && hyp_en && hyp_acc_trap) |=>
      (resp_trap && resp_syn == SYN_ONE && !resp_undef));
  // R5: Secure level 3 access is undefined
  a_r5_sec_el3_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && cur_el == 2'd3 && sec_state) |=> resp_undef);
  // R1: unselected encoding leaves the stored word alone
  a_r1_miss_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> ($stable(cfg_q) && !resp_undef && !resp_trap));
  // R6 and R12: reserved and absent bits read as zero
  a_r6_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ((resp_rdata & ~WMASK) == 32'h0));
  // R8: host mode masks the trap group
  a_r8_host_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (host_e2h && host_tge) |-> ((eff_ctrl & GRP_TRAP) == 32'h0));
  // R9: Secure execution never takes a guest trap
  a_r9_secure_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    sec_state |-> !guest_trap);
  // R11: a stalled response stays put
  a_r11_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata) &&
                                     $stable(resp_undef) && $stable(resp_trap)));
  // R3/R5: undefined and trap never together
  a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_undef && resp_trap));
endmodule

// File: tb/test_hv_trap_ctl.sv
`timescale 1ns/1ps
module test_hv_trap_ctl;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic req_valid = 0, req_write = 0, resp_ready = 1;
  logic [3:0] req_cp = 15, req_crn = 1, req_crm = 1;
  logic [2:0] req_opc1 = 4, req_opc2 = 4;
  logic [31:0] req_wdata = 0;
  logic [1:0] cur_el = 2;
  logic sec_state = 0, hyp_en = 0, hyp_acc_trap = 0, host_e2h = 0, host_tge = 0, s2_en = 0;
  logic [5:0] insn_class = 0;

  logic req_ready, resp_valid, resp_undef, resp_trap, guest_trap;
  logic [31:0] resp_rdata, eff_ctrl;
  logic [5:0] resp_syn, guest_syn;
  logic l_rdy, l_vld, l_und, l_trp, l_gt;
  logic [31:0] l_rd, l_eff;
  logic [5:0] l_syn, l_gs;

  hv_trap_ctl i_hv_trap_ctl (.*);

  hv_trap_ctl #(.HAS_TRAP_GRP(1'b0), .HAS_RAS_GRP(1'b0), .HAS_NCOH(1'b0)) i_hv_trap_ctl_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_rdy), .req_cp(req_cp),
    .req_opc1(req_opc1), .req_crn(req_crn), .req_crm(req_crm), .req_opc2(req_opc2),
    .req_write(req_write), .req_wdata(req_wdata), .resp_valid(l_vld), .resp_ready(resp_ready),
    .resp_rdata(l_rd), .resp_undef(l_und), .resp_trap(l_trp), .resp_syn(l_syn),
    .cur_el(cur_el), .sec_state(sec_state), .hyp_en(hyp_en), .hyp_acc_trap(hyp_acc_trap),
    .host_e2h(host_e2h), .host_tge(host_tge), .s2_en(s2_en), .insn_class(insn_class),
    .guest_trap(l_gt), .guest_syn(l_gs), .eff_ctrl(l_eff));

  int n_chk = 0, n_fail = 0;
  localparam logic [31:0] ALLF = 32'h0056_0073;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] cp, input logic [2:0] o2, input logic [1:0] el,
                        input logic sec, input logic he, input logic ht,
                        input logic wr, input logic [31:0] wd);
    @(negedge clk);
    req_cp = cp; req_opc2 = o2; cur_el = el; sec_state = sec; hyp_en = he;
    hyp_acc_trap = ht; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0] el; logic sec; logic he; logic ht; logic wr; logic [31:0] wd;
    logic undef; logic trap; logic [5:0] syn; logic [31:0] rd;
  } vec_t;

  // R2 R3 R4 R5 R6 sequence against the full build
  localparam vec_t VECS [13] = '{
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 6'h00, 32'h0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 6'h00, 32'h0056_0073},
    '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,         1'b1, 1'b0, 6'h00, 32'h0},
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0,         1'b0, 1'b1, 6'h03, 32'h0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 6'h00, 32'h0056_0073},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 6'h00, 32'h0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         1'b1, 1'b0, 6'h00, 32'h0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,         1'b1, 1'b0, 6'h00, 32'h0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 6'h00, 32'h0056_0073},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0040_0011, 1'b0, 1'b0, 6'h00, 32'h0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 6'h00, 32'h0040_0011},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_A5A5, 1'b0, 1'b0, 6'h00, 32'h0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 6'h00, 32'h0004_0021}
  };

  task automatic guest(input logic [1:0] el, input logic sec, input logic e2h, input logic tge,
                       input logic [5:0] cls, input logic exp_t, input logic [5:0] exp_s,
                       input string tag);
    @(negedge clk);
    cur_el = el; sec_state = sec; host_e2h = e2h; host_tge = tge; insn_class = cls;
    #1;
    chk(guest_trap == exp_t && guest_syn == exp_s, tag, {25'd0, guest_trap, guest_syn},
        {25'd0, exp_t, exp_s});
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    chk(eff_ctrl == 0 && !resp_valid && req_ready, "R7 reset outputs", eff_ctrl, 0);
    access(15, 4, 2, 0, 0, 0, 0, 0);
    chk(resp_valid && resp_rdata == 0, "R7 read after reset", resp_rdata, 0);

    foreach (VECS[i]) begin
      access(15, 4, VECS[i].el, VECS[i].sec, VECS[i].he, VECS[i].ht, VECS[i].wr, VECS[i].wd);
      chk(resp_valid && resp_undef == VECS[i].undef && resp_trap == VECS[i].trap &&
          resp_syn == VECS[i].syn && resp_rdata == VECS[i].rd,
          $sformatf("R2-R6 vector %0d", i), resp_rdata, VECS[i].rd);
    end

    // R1: non-selected encodings
    access(14, 4, 2, 0, 0, 0, 1, 32'hFFFF_FFFF);
    chk(resp_valid && !resp_undef && !resp_trap && resp_rdata == 0, "R1 wrong cp", resp_rdata, 0);
    access(15, 3, 2, 0, 0, 0, 0, 0);
    chk(resp_rdata == 0 && !resp_undef, "R1 wrong opc2 read", resp_rdata, 0);
    access(15, 4, 2, 0, 0, 0, 0, 0);
    chk(resp_rdata == 32'h0004_0021, "R1 word unchanged", resp_rdata, 32'h0004_0021);

    // R12: lite build kept only bits 1:0
    access(15, 4, 2, 0, 0, 0, 1, ALLF);
    access(15, 4, 2, 0, 0, 0, 0, 0);
    chk(l_vld && l_rd == 32'h3, "R12 absent groups read zero", l_rd, 32'h3);
    chk(resp_rdata == ALLF, "R4 full build all fields", resp_rdata, ALLF);

    // R9: guest trap mapping
    guest(1, 0, 0, 0, 6'b000001, 1, 6'h03, "R9 tlb is");
    guest(1, 0, 0, 0, 6'b000010, 1, 6'h03, "R9 pou");
    guest(1, 0, 0, 0, 6'b000100, 1, 6'h03, "R9 icab");
    guest(1, 0, 0, 0, 6'b010000, 1, 6'h03, "R9 err single");
    guest(1, 0, 0, 0, 6'b100000, 1, 6'h04, "R9 err double");
    guest(0, 0, 0, 0, 6'b001000, 1, 6'h03, "R9 id4 at el0");
    guest(0, 0, 0, 0, 6'b000001, 0, 6'h00, "R9 tlb at el0");
    guest(2, 0, 0, 0, 6'b000001, 0, 6'h00, "R9 tlb at el2");
    guest(1, 1, 0, 0, 6'b000001, 0, 6'h00, "R9 secure el1");
    // R8: host mode
    guest(1, 0, 1, 1, 6'b000001, 0, 6'h00, "R8 host tlb");
    guest(0, 0, 1, 1, 6'b001000, 0, 6'h00, "R8 host id4");
    guest(1, 0, 1, 1, 6'b010000, 1, 6'h03, "R8 host err still traps");
    chk((eff_ctrl & 32'h0056_0000) == 0, "R8 host eff mask", eff_ctrl, 0);
    guest(1, 0, 1, 0, 6'b000001, 1, 6'h03, "R8 e2h alone");

    // R10: stage-2 gating
    @(negedge clk); s2_en = 0; cur_el = 1; #1;
    chk(eff_ctrl == 32'h0056_0070, "R10 s2 off", eff_ctrl, 32'h0056_0070);
    @(negedge clk); s2_en = 1; #1;
    chk(eff_ctrl == ALLF, "R10 s2 on el1", eff_ctrl, ALLF);
    @(negedge clk); cur_el = 2; #1;
    chk(eff_ctrl == 32'h0056_0070, "R10 s2 on el2", eff_ctrl, 32'h0056_0070);

    // R11: back-pressure
    @(negedge clk); insn_class = 0; resp_ready = 0;
    access(15, 4, 2, 0, 0, 0, 0, 0);
    chk(resp_valid && !req_ready && resp_rdata == ALLF, "R11 stall first", resp_rdata, ALLF);
    repeat (2) @(negedge clk);
    chk(resp_valid && !req_ready && resp_rdata == ALLF, "R11 stall held", resp_rdata, ALLF);
    resp_ready = 1;
    @(negedge clk);
    chk(!resp_valid && req_ready, "R11 drained", {31'd0, resp_valid}, 0);

    // R7: reset mid-run
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    access(15, 4, 2, 0, 0, 0, 0, 0);
    chk(resp_rdata == 0, "R7 reset clears", resp_rdata, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule